// File: doc/BRIEF.md
# Signed-Magnitude Adder-Subtracter

This block is a combinational arithmetic unit for sign-and-magnitude numbers. It takes two N-bit operands and an operation select, and returns an N-bit sign-and-magnitude result together with an overflow flag. It is meant for datapaths that hold values as a sign bit followed by a magnitude, where a plain binary adder gives wrong answers. Two cases show why: adding values of opposite sign, and subtracting a larger magnitude from a smaller one.

A subtraction is turned into an addition by flipping the sign of the second operand. After that, a single path decides between two cases. If the effective signs agree, the magnitudes are added and the shared sign is kept. If they differ, the operands are put in order so that the larger magnitude comes first. The smaller magnitude is then taken from the larger, and the result takes the sign of the larger operand. A zero result is always given as positive zero. When a same-sign sum does not fit in the magnitude field, the overflow flag is raised and the magnitude wraps.

Top module: `sm_addsub`

## Requirements
- R1: Each operand and the result use bit N-1 as the sign (1 means negative, 0 means non-negative) and bits N-2..0 as an unsigned magnitude. With N=4 the value range is -7..+7.
- R2: When the effective signs agree and the magnitude sum is below 2^(N-1), the result magnitude is the sum of the magnitudes and the result sign is the shared sign. The overflow flag is 0.
- R3: When the effective signs agree and the magnitude sum is 2^(N-1) or more, the overflow flag is 1, the result magnitude is the sum modulo 2^(N-1) and the sign is the shared sign (for example 7+7 gives +6 with overflow).
- R4: When the effective signs differ, the result magnitude is the larger magnitude minus the smaller one, and the result sign is that of the operand with the larger magnitude (for example -2 + 6 gives +4, and 2 + -6 gives -4).
- R5: With the operation select at 1, the sign of the second operand is inverted before R2 to R4 apply (for example 2 - 3 gives -1, and -5 - 4 gives -1 with overflow).
- R6: A zero result magnitude is always output with the sign bit at 0. The encoding 1 followed by all-zero magnitude never appears on the result.
- R7: Both encodings of zero (+0 and -0) are accepted as inputs and act as the value zero (for example -0 + +3 gives +3, and -0 + -0 gives +0).
- R8: The overflow flag is 0 whenever the effective signs differ.
- R9: Operands of equal magnitude and differing effective sign give +0 (for example -5 + 5 gives +0 and not -10).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | N | First operand, sign-and-magnitude |
| opb | input | N | Second operand, sign-and-magnitude |
| op_sub | input | 1 | 0 selects opa + opb, 1 selects opa - opb |
| res | output | N | Result, sign-and-magnitude, zero is always +0 |
| res_ovf | output | 1 | Magnitude carry-out of a same-sign sum |

## Verification
Overflow wrap and zero normalisation can both act on the same result. This happens when two same-sign magnitudes add up to exactly 2^(N-1), so the wrapped magnitude is zero. The bench provokes this with +4 + +4 and -4 + -4, and also through subtraction. It expects +0 with the overflow flag set: the sign must be dropped even though both inputs were negative. A full sweep of all operand pairs under both operations compares every result against an integer model, which also covers the cases that involve -0 and equal magnitudes.

// File: rtl/sm_arith_pkg.sv
// Package: shared types for the sign-and-magnitude arithmetic unit.
// Assumes: nothing beyond the consumers agreeing on the path encoding.
package sm_arith_pkg;

    // Selects which magnitude operation the common path performs.
    typedef enum logic {
        PATH_SUM  = 1'b0,   // effective signs agree: add magnitudes
        PATH_DIFF = 1'b1    // effective signs differ: subtract magnitudes
    } sm_path_e;

endpackage

// File: rtl/sm_operand_prep.sv
// Module: sm_operand_prep
// Splits both operands into sign and magnitude, inverts the sign of the
// second operand for a subtraction, and picks the magnitude path.
// Assumes: W >= 2; inputs are sign-and-magnitude with the sign in bit W-1.
module sm_operand_prep
    import sm_arith_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         op_sub,
    output logic         a_neg,
    output logic         b_neg_eff,
    output logic [W-2:0] a_mag,
    output logic [W-2:0] b_mag,
    output sm_path_e     path
);

    // Field split and sign inversion for subtraction (R1, R5).
    always_comb begin
        a_neg     = opa[W-1];
        b_neg_eff = opb[W-1] ^ op_sub;
        a_mag     = opa[W-2:0];
        b_mag     = opb[W-2:0];
    end

    // Path choice from the effective signs (R2, R4).
    always_comb begin
        path = (a_neg == b_neg_eff) ? PATH_SUM : PATH_DIFF;
    end

endmodule

// File: rtl/sm_mag_order.sv
// Module: sm_mag_order
// Compares two magnitudes and routes the larger to the first output,
// carrying with it the sign of the operand it came from.
// Assumes: magnitudes are unsigned; on a tie the first operand is chosen.
module sm_mag_order #(
    parameter int MW = 3
) (
    input  logic [MW-1:0] a_mag,
    input  logic [MW-1:0] b_mag,
    input  logic          a_neg,
    input  logic          b_neg,
    output logic [MW-1:0] big_mag,
    output logic [MW-1:0] small_mag,
    output logic          big_neg
);

    logic a_ge_b;

    // Magnitude comparison deciding the swap (R4).
    always_comb begin
        a_ge_b = (a_mag >= b_mag);
    end

    // Swap network: larger magnitude first, with its sign (R4).
    always_comb begin
        if (a_ge_b) begin
            big_mag   = a_mag;
            small_mag = b_mag;
            big_neg   = a_neg;
        end else begin
            big_mag   = b_mag;
            small_mag = a_mag;
            big_neg   = b_neg;
        end
    end

endmodule

// File: rtl/sm_mag_alu.sv
// Module: sm_mag_alu
// Ripple-carry unsigned magnitude adder/subtracter. Subtraction uses the
// inverted subtrahend with a carry-in of one.
// Assumes: for a subtraction the caller has ordered x >= y.
module sm_mag_alu #(
    parameter int MW = 3
) (
    input  logic [MW-1:0] x,
    input  logic [MW-1:0] y,
    input  logic          do_sub,
    output logic [MW-1:0] sum,
    output logic          carry_out
);

    logic [MW-1:0] y_eff;
    logic [MW:0]   c;

    // Operand conditioning: invert y and inject carry for subtraction.
    always_comb begin
        y_eff = do_sub ? ~y : y;
        c[0]  = do_sub;
    end

    // One full-adder cell per magnitude bit.
    genvar i;
    generate
        for (i = 0; i < MW; i++) begin : g_cell
            always_comb begin
                sum[i]  = x[i] ^ y_eff[i] ^ c[i];
                c[i+1]  = (x[i] & y_eff[i]) | (c[i] & (x[i] ^ y_eff[i]));
            end
        end
    endgenerate

    // Carry out of the top cell.
    always_comb begin
        carry_out = c[MW];
    end

    // An ordered subtraction never borrows (R4).
    always_comb begin
        if (do_sub) begin
            a_r4_no_borrow: assert (carry_out == 1'b1)
                else $error("ordered magnitude subtraction borrowed");
        end
    end

endmodule

// File: rtl/sm_addsub.sv
// Module: sm_addsub (top)
// Combinational sign-and-magnitude adder-subtracter with overflow flag.
// Assumes: N >= 2; no clock, no state, result settles within the cycle.
module sm_addsub
    import sm_arith_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0] opa,
    input  logic [N-1:0] opb,
    input  logic         op_sub,
    output logic [N-1:0] res,
    output logic         res_ovf
);

    localparam int MW = N - 1;

    logic          a_neg;
    logic          b_neg_eff;
    logic [MW-1:0] a_mag;
    logic [MW-1:0] b_mag;
    sm_path_e      path;
    logic [MW-1:0] big_mag;
    logic [MW-1:0] small_mag;
    logic          big_neg;
    logic [MW-1:0] mag_out;
    logic          carry;
    logic          sign_raw;

    sm_operand_prep #(.W(N)) u_prep (
        .opa       (opa),
        .opb       (opb),
        .op_sub    (op_sub),
        .a_neg     (a_neg),
        .b_neg_eff (b_neg_eff),
        .a_mag     (a_mag),
        .b_mag     (b_mag),
        .path      (path)
    );

    sm_mag_order #(.MW(MW)) u_order (
        .a_mag     (a_mag),
        .b_mag     (b_mag),
        .a_neg     (a_neg),
        .b_neg     (b_neg_eff),
        .big_mag   (big_mag),
        .small_mag (small_mag),
        .big_neg   (big_neg)
    );

    sm_mag_alu #(.MW(MW)) u_alu (
        .x         (big_mag),
        .y         (small_mag),
        .do_sub    (path == PATH_DIFF),
        .sum       (mag_out),
        .carry_out (carry)
    );

    // Sign selection: shared sign on a sum, larger operand's sign on a difference.
    always_comb begin
        sign_raw = (path == PATH_SUM) ? a_neg : big_neg;
    end

    // Result assembly with zero forced positive (R6) and overflow (R3, R8).
    always_comb begin
        res     = {(sign_raw && (mag_out != '0)), mag_out};
        res_ovf = (path == PATH_SUM) && carry;
    end

    // Guards on the assembled result.
    always_comb begin
        // R6: negative zero never leaves the block.
        a_r6_no_neg_zero: assert (res != {1'b1, {MW{1'b0}}})
            else $error("negative zero on result");
        // R8: differing effective signs cannot overflow.
        if (opa[N-1] != (opb[N-1] ^ op_sub)) begin
            a_r8_no_ovf_on_diff: assert (!res_ovf)
                else $error("overflow flagged on a difference");
            // R4: a difference never exceeds the larger input magnitude.
            a_r4_diff_bounded: assert ((res[MW-1:0] <= opa[MW-1:0]) || (res[MW-1:0] <= opb[MW-1:0]))
                else $error("difference larger than both inputs");
        end else if (!res_ovf) begin
            // R2: a same-sign sum that fits is no smaller than either input.
            a_r2_sum_grows: assert ((res[MW-1:0] >= opa[MW-1:0]) && (res[MW-1:0] >= opb[MW-1:0]))
                else $error("same-sign sum shrank without overflow");
        end
    end

endmodule

// File: tb/sm_addsub_test.sv
// Bench for sm_addsub: directed vector table, exhaustive sweep against an
// integer model, and a time-zero check. Inputs change after a rising edge,
// outputs are sampled at the following falling edge.
module sm_addsub_test;

    localparam int N    = 4;
    localparam int MW   = N - 1;
    localparam int MODM = 2 ** MW;
    localparam int NV   = 16;

    // Entry layout: {sub, a[3:0], b[3:0], expected res[3:0], expected ovf}
    localparam logic [13:0] VEC [NV] = '{
        14'b0_1101_0101_0000_0,   // R9: -5 + 5 = +0
        14'b1_0010_0011_1001_0,   // R5: 2 - 3 = -1
        14'b1_0011_0010_0001_0,   // R5: 3 - 2 = +1
        14'b0_0011_0011_0110_0,   // R2: 3 + 3 = +6
        14'b0_0100_0100_0000_1,   // R3/R6: 4 + 4 wraps to +0
        14'b0_1100_1100_0000_1,   // R3/R6: -4 + -4 wraps to +0
        14'b0_0111_0111_0110_1,   // R3: 7 + 7 = +6 wrapped
        14'b0_1111_1010_1001_1,   // R3: -7 + -2 = -1 wrapped
        14'b0_1000_1000_0000_0,   // R7: -0 + -0 = +0
        14'b0_1000_0011_0011_0,   // R7: -0 + 3 = +3
        14'b1_1000_0000_0000_0,   // R7: -0 - +0 = +0
        14'b1_1011_1011_0000_0,   // R9: -3 - -3 = +0
        14'b0_1010_0110_0100_0,   // R4: -2 + 6 = +4, no R8 overflow
        14'b0_0010_1110_1100_0,   // R4: 2 + -6 = -4
        14'b1_1101_0100_1001_1,   // R5: -5 - 4 = -1 wrapped
        14'b1_0101_1001_0110_0    // R5: 5 - -1 = +6
    };
    localparam string TAG [NV] = '{
        "R9", "R5", "R5", "R2", "R3", "R3", "R3", "R3",
        "R7", "R7", "R7", "R9", "R8", "R4", "R5", "R5"
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] opa = '0;
    logic [N-1:0] opb = '0;
    logic         op_sub = 1'b0;
    logic [N-1:0] res;
    logic         res_ovf;
    int           n_checks = 0;
    int           n_fail = 0;
    bit           done = 1'b0;

    sm_addsub #(.N(N)) uut (
        .opa     (opa),
        .opb     (opb),
        .op_sub  (op_sub),
        .res     (res),
        .res_ovf (res_ovf)
    );

    // 250 MHz clock.
    always #2 clk = ~clk;

    // Integer reference: returns {ovf, res}.
    function automatic logic [N:0] model(input logic s, input logic [N-1:0] x, input logic [N-1:0] y);
        int va;
        int vb;
        int r;
        int mag;
        int m;
        logic o;
        logic ng;
        va  = int'(x[MW-1:0]);
        vb  = int'(y[MW-1:0]);
        if (x[N-1]) va = -va;
        if (y[N-1] ^ s) vb = -vb;
        r   = va + vb;
        mag = (r < 0) ? -r : r;
        o   = (mag >= MODM);
        m   = mag % MODM;
        ng  = (r < 0) && (m != 0);
        return {o, ng, m[MW-1:0]};
    endfunction

    task automatic check(input string tag, input logic [N-1:0] exp_r, input logic exp_o);
        n_checks++;
        if (res !== exp_r || res_ovf !== exp_o) begin
            n_fail++;
            $display("FAIL %s: a=%b b=%b sub=%b got res=%b ovf=%b expected res=%b ovf=%b",
                     tag, opa, opb, op_sub, res, res_ovf, exp_r, exp_o);
        end
    endtask

    task automatic apply(input logic s, input logic [N-1:0] x, input logic [N-1:0] y);
        @(posedge clk);
        op_sub = s;
        opa    = x;
        opb    = y;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // Reset phase and time-zero result: R1 encoding of +0 + +0 is all zeros.
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset-state", '0, 1'b0);

        // Directed table.
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][13], VEC[i][12:9], VEC[i][8:5]);
            check(TAG[i], VEC[i][4:1], VEC[i][0]);
        end

        // Exhaustive sweep for both operations.
        for (int s = 0; s < 2; s++) begin
            for (int x = 0; x < 2 ** N; x++) begin
                for (int y = 0; y < 2 ** N; y++) begin
                    logic [N:0] e;
                    string      t;
                    apply(s[0], x[N-1:0], y[N-1:0]);
                    e = model(s[0], x[N-1:0], y[N-1:0]);
                    if (e[N])                                   t = "R3";
                    else if (x[MW-1:0] == 0 || y[MW-1:0] == 0)  t = "R7";
                    else if (e[N-1:0] == '0)                    t = "R6";
                    else if (s != 0)                            t = "R5";
                    else if (x[N-1] == y[N-1])                  t = "R2";
                    else                                        t = "R4";
                    check(t, e[N-1:0], e[N]);
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule